// File: doc/BRIEF.md
# Fractional-N PLL Divider Calculator

This block turns a reference frequency and a wanted output frequency, both given as 32-bit integers in hertz, into the settings of a fractional-N synthesiser. It picks a post-divider that lifts the output into a 90 to 100 MHz oscillator window. It may halve the reference. It then finds the integer multiplier N and a 22-bit fraction K. The results come out as separate fields and also packed into four 9-bit configuration words, ready to be loaded into the synthesiser.

A calculation starts with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, with `err` raised in the same cycle when the request cannot be met. While the four configuration words are loaded, the synthesiser power-down output is held high. It is released only after the last word is in place. One restoring divider is shared between the integer quotient and the fraction, so no arithmetic IP is needed.

Top module: `pll_frac_calc`

## Requirements
- R1: The post-divider candidates are tried in this fixed order, as (divide, mode, post bit): (2,0,0), (4,0,1), (4,1,0), (8,1,1), (8,2,0), (16,2,1), (12,3,0), (24,3,1). The first candidate whose target times divide lies in 90,000,000..100,000,000 inclusive drives `fmode` and `post_div`.
- R2: When no candidate places the scaled target in the window, `done` and `err` pulse together.
- R3: N is the scaled target divided by the reference. If that is below 5, the reference is halved (integer floor), `pre_half` is set, and N is computed again with the halved reference.
- R4: If N is still below 5 or above 13 after R3, `done` and `err` pulse together. The values 5 and 13 themselves are accepted.
- R5: `k_frac` equals floor(2^22 × (scaled target mod reference) / reference), using the reference left after R3.
- R6: `img_k_low` holds K[8:0]. `img_k_mid` holds K[16:9] in bits 7..0 with bit 8 zero. `img_n_k` holds K[21:18] in bits 3..0, N in bits 7..4 and zero in bit 8.
- R7: `img_mode` holds pre_half in bit 0, post_div in bit 1 and fmode in bits 5..4. Bits 8..6 and 3..2 are copied from `cfg_keep`, sampled at start.
- R8: After a successful calculation, `pll_pd` is high before the first configuration word changes and stays high while the words change. It falls in the cycle `done` pulses. A zero reference or zero target gives `done` without `err`, drives `pll_pd` high, and leaves fields and words unchanged.
- R9: `err` is only ever high together with `done`. On an error, all fields, words and `pll_pd` keep their previous values.
- R10: A `start` pulse while `busy` is high is ignored. The running calculation finishes with its own operands.
- R11: After reset, `done`, `err` and `busy` are low, `pll_pd` is high, and all fields and words are zero.
- R12: `done` pulses no more than 128 cycles after the `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a calculation |
| ref_hz | input | 32 | Reference frequency in Hz |
| tgt_hz | input | 32 | Wanted output frequency in Hz |
| cfg_keep | input | 9 | Existing mode word; its unused bits are kept |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request cannot be met; valid with done |
| pll_pd | output | 1 | Synthesiser power-down control |
| fmode | output | 2 | Post-divider frequency mode |
| post_div | output | 1 | Post-divider extra halving bit |
| pre_half | output | 1 | Reference halving bit |
| n_int | output | 4 | Integer multiplier N |
| k_frac | output | 22 | Fractional multiplier K |
| img_k_low | output | 9 | Configuration word 1 |
| img_k_mid | output | 9 | Configuration word 2 |
| img_n_k | output | 9 | Configuration word 3 |
| img_mode | output | 9 | Configuration word 4 |

## Verification
The hardest path to reach is the second division. It runs only when the first quotient is below 5. Its own outcome can then land inside or outside the 5..13 range. The stimulus therefore uses reference and target pairs chosen so that N after halving is exactly 5, so that it stays far below range, and so that a plain case sits on the upper limit of 13. Targets that sit on both window edges, and targets that two candidates would both accept, check the first-match order. A second start pulse issued mid-run shows that the running calculation keeps its first operands.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;

  typedef struct packed {
    logic [4:0] div;
    logic [1:0] fmode;
    logic       post;
  } post_ent_t;

  localparam int unsigned TBL_LEN = 8;

  // candidate order is behaviour: first match wins
  function automatic post_ent_t post_entry(input logic [2:0] i);
    case (i)
      3'd0:    post_entry = '{div: 5'd2,  fmode: 2'd0, post: 1'b0};
      3'd1:    post_entry = '{div: 5'd4,  fmode: 2'd0, post: 1'b1};
      3'd2:    post_entry = '{div: 5'd4,  fmode: 2'd1, post: 1'b0};
      3'd3:    post_entry = '{div: 5'd8,  fmode: 2'd1, post: 1'b1};
      3'd4:    post_entry = '{div: 5'd8,  fmode: 2'd2, post: 1'b0};
      3'd5:    post_entry = '{div: 5'd16, fmode: 2'd2, post: 1'b1};
      3'd6:    post_entry = '{div: 5'd12, fmode: 2'd3, post: 1'b0};
      default: post_entry = '{div: 5'd24, fmode: 2'd3, post: 1'b1};
    endcase
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_DIVN, S_DIVK, S_LOAD, S_REL
  } calc_st_t;

endpackage

// File: rtl/pllcalc_scan.sv
module pllcalc_scan
  import pllcalc_pkg::*;
#(
  parameter int FW     = 32,
  parameter int WIN_LO = 90_000_000,
  parameter int WIN_HI = 100_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] tgt,
  output logic          done,
  output logic          hit,
  output logic [1:0]    fmode,
  output logic          post,
  output logic [FW-1:0] scaled
);
  localparam int PW = FW + 5;
  localparam int IW = $clog2(TBL_LEN);

  logic [IW-1:0] idx;
  logic          run;
  logic [FW-1:0] tgt_q;
  post_ent_t     ent;
  logic [PW-1:0] prod;
  logic          in_win;

  assign ent    = post_entry(3'(idx));
  assign prod   = {5'b0, tgt_q} * {{FW{1'b0}}, ent.div};
  assign in_win = (prod >= PW'(WIN_LO)) && (prod <= PW'(WIN_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; idx <= '0; tgt_q <= '0; done <= 1'b0; hit <= 1'b0;
      fmode <= '0; post <= 1'b0; scaled <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1; idx <= '0; tgt_q <= tgt;
      end else if (run) begin
        if (in_win) begin
          run <= 1'b0; done <= 1'b1; hit <= 1'b1;
          fmode <= ent.fmode; post <= ent.post; scaled <= prod[FW-1:0];
        end else if (idx == IW'(TBL_LEN - 1)) begin
          run <= 1'b0; done <= 1'b1; hit <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R1: a reported hit always lies inside the window
  a_r1_hit_in_window: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |-> (scaled >= FW'(WIN_LO) && scaled <= FW'(WIN_HI)));
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pllcalc_div.sv
module pllcalc_div #(
  parameter int DW = 32,
  parameter int FW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          frac,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sh, r, d;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial, diff;
  logic          ge;

  assign trial = {r, sh[DW-1]};
  assign ge    = trial >= {1'b0, d};
  assign diff  = trial - {1'b0, d};
  assign quo   = sh;
  assign rem   = r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; r <= '0; d <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        d   <= divisor;
        r   <= frac ? dividend : '0;
        sh  <= frac ? '0 : dividend;
        cnt <= frac ? CW'(FW) : CW'(DW);
      end else if (run) begin
        r   <= ge ? diff[DW-1:0] : trial[DW-1:0];
        sh  <= {sh[DW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0; done <= 1'b1;
        end
      end
    end
  end

  // R5: the partial remainder stays below the divisor on every step
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    run |-> (r < d));
endmodule

// File: rtl/pllcalc_pack.sv
module pllcalc_pack #(
  parameter int KW = 22,
  parameter int NW = 4,
  parameter int RW = 9
) (
  input  logic [KW-1:0]        k,
  input  logic [NW-1:0]        n,
  input  logic [1:0]           fm,
  input  logic                 post,
  input  logic                 pre,
  input  logic [RW-1:0]        keep,
  output logic [3:0][RW-1:0]   img
);
  always_comb begin
    img[0] = RW'(k[8:0]);
    img[1] = RW'(k[16:9]);
    img[2] = RW'({n, k[21:18]});
    img[3] = keep;
    img[3][0]   = pre;
    img[3][1]   = post;
    img[3][5:4] = fm;
  end
endmodule

// File: rtl/pll_frac_calc.sv
module pll_frac_calc
  import pllcalc_pkg::*;
#(
  parameter int FW    = 32,
  parameter int KW    = 22,
  parameter int NW    = 4,
  parameter int RW    = 9,
  parameter int N_MIN = 5,
  parameter int N_MAX = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] ref_hz,
  input  logic [FW-1:0] tgt_hz,
  input  logic [RW-1:0] cfg_keep,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          pll_pd,
  output logic [1:0]    fmode,
  output logic          post_div,
  output logic          pre_half,
  output logic [NW-1:0] n_int,
  output logic [KW-1:0] k_frac,
  output logic [RW-1:0] img_k_low,
  output logic [RW-1:0] img_k_mid,
  output logic [RW-1:0] img_n_k,
  output logic [RW-1:0] img_mode
);
  localparam int IMG_N = 4;
  localparam int LW    = $clog2(IMG_N);

  calc_st_t       st;
  logic [FW-1:0]  ref_w;
  logic [RW-1:0]  keep_q;
  logic           pre_w, post_w;
  logic [1:0]     fm_w;
  logic [NW-1:0]  n_w;
  logic [KW-1:0]  k_w;
  logic [LW-1:0]  ld_idx;
  logic [RW-1:0]  img_q [IMG_N];
  logic [IMG_N-1:0][RW-1:0] pk;

  logic           sc_start, sc_done, sc_hit, sc_post;
  logic [1:0]     sc_fm;
  logic [FW-1:0]  sc_scaled;

  logic           dv_start, dv_frac, dv_done;
  logic [FW-1:0]  dv_num, dv_den, dv_quo, dv_rem;
  logic           n_small, n_bad, zero_req;

  assign busy     = (st != S_IDLE);
  assign zero_req = (ref_hz == '0) || (tgt_hz == '0);
  assign sc_start = (st == S_IDLE) && start && !zero_req;
  assign n_small  = dv_quo < FW'(N_MIN);
  assign n_bad    = n_small || (dv_quo > FW'(N_MAX));

  pllcalc_scan #(.FW(FW)) u_scan (
    .clk(clk), .rst(rst), .start(sc_start), .tgt(tgt_hz),
    .done(sc_done), .hit(sc_hit), .fmode(sc_fm), .post(sc_post),
    .scaled(sc_scaled));

  pllcalc_div #(.DW(FW), .FW(KW)) u_div (
    .clk(clk), .rst(rst), .start(dv_start), .frac(dv_frac),
    .dividend(dv_num), .divisor(dv_den),
    .done(dv_done), .quo(dv_quo), .rem(dv_rem));

  pllcalc_pack #(.KW(KW), .NW(NW), .RW(RW)) u_pack (
    .k(k_w), .n(n_w), .fm(fm_w), .post(post_w), .pre(pre_w),
    .keep(keep_q), .img(pk));

  // divider launch: integer pass, optional retry on halved reference, fraction pass
  always_comb begin
    dv_start = 1'b0;
    dv_frac  = 1'b0;
    dv_num   = sc_scaled;
    dv_den   = ref_w;
    case (st)
      S_SCAN: dv_start = sc_done && sc_hit;
      S_DIVN: if (dv_done) begin
        if (n_small && !pre_w) begin
          dv_start = 1'b1;
          dv_den   = ref_w >> 1;
        end else if (!n_bad) begin
          dv_start = 1'b1;
          dv_frac  = 1'b1;
          dv_num   = dv_rem;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ref_w <= '0; keep_q <= '0; pre_w <= 1'b0; post_w <= 1'b0;
      fm_w <= '0; n_w <= '0; k_w <= '0; ld_idx <= '0;
      done <= 1'b0; err <= 1'b0; pll_pd <= 1'b1;
      fmode <= '0; post_div <= 1'b0; pre_half <= 1'b0; n_int <= '0; k_frac <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ref_w  <= ref_hz;
          keep_q <= cfg_keep;
          pre_w  <= 1'b0;
          if (zero_req) begin
            pll_pd <= 1'b1;
            done   <= 1'b1;
          end else begin
            st <= S_SCAN;
          end
        end
        S_SCAN: if (sc_done) begin
          if (sc_hit) begin
            fm_w <= sc_fm; post_w <= sc_post; st <= S_DIVN;
          end else begin
            done <= 1'b1; err <= 1'b1; st <= S_IDLE;
          end
        end
        S_DIVN: if (dv_done) begin
          if (n_small && !pre_w) begin
            pre_w <= 1'b1;
            ref_w <= ref_w >> 1;
          end else if (n_bad) begin
            done <= 1'b1; err <= 1'b1; st <= S_IDLE;
          end else begin
            n_w <= dv_quo[NW-1:0];
            st  <= S_DIVK;
          end
        end
        S_DIVK: if (dv_done) begin
          k_w    <= dv_quo[KW-1:0];
          pll_pd <= 1'b1;
          ld_idx <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          ld_idx <= ld_idx + 1'b1;
          if (ld_idx == LW'(IMG_N - 1)) st <= S_REL;
        end
        S_REL: begin
          pll_pd <= 1'b0; done <= 1'b1;
          fmode <= fm_w; post_div <= post_w; pre_half <= pre_w;
          n_int <= n_w; k_frac <= k_w;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // one configuration word per load cycle
  for (genvar g = 0; g < IMG_N; g++) begin : g_img
    always_ff @(posedge clk) begin
      if (rst) img_q[g] <= '0;
      else if (st == S_LOAD && ld_idx == LW'(g)) img_q[g] <= pk[g];
    end
  end

  assign img_k_low = img_q[0];
  assign img_k_mid = img_q[1];
  assign img_n_k   = img_q[2];
  assign img_mode  = img_q[3];

  // R8: words only change while the synthesiser is held down
  a_r8_words_change_in_pd: assert property (@(posedge clk) disable iff (rst)
    !$stable({img_k_low, img_k_mid, img_n_k, img_mode}) |-> pll_pd);
  // R8: release comes with a successful completion
  a_r8_release_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pd) |-> (done && !err));
  // R9: error never appears without done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R4: a released synthesiser has N in range
  a_r4_n_in_range: assert property (@(posedge clk) disable iff (rst)
    (done && !pll_pd) |-> (n_int >= NW'(N_MIN) && n_int <= NW'(N_MAX)));
  // R10: completion returns the block to idle
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_pll_frac_calc.sv
module tb_pll_frac_calc;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam int LAT_MAX = 128;

  localparam logic [31:0] V_REF [NV] = '{
    32'd12_000_000, 32'd27_000_000, 32'd12_000_000, 32'd12_000_000,
    32'd12_000_000, 32'd12_000_000, 32'd12_000_000, 32'd12_000_000,
    32'd24_576_000, 32'd12_000_000, 32'd1_000_000,  32'd100_000_000,
    32'd33_333_333, 32'd7_000_000};
  localparam logic [31:0] V_TGT [NV] = '{
    32'd12_288_000, 32'd11_289_600, 32'd45_000_000, 32'd50_000_000,
    32'd24_000_000, 32'd11_250_000, 32'd6_000_000,  32'd4_000_000,
    32'd12_000_000, 32'd50_000_001, 32'd12_288_000, 32'd12_288_000,
    32'd12_000_000, 32'd12_000_000};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] ref_hz = '0, tgt_hz = '0;
  logic [8:0]  cfg_keep = '0;
  logic busy, done, err, pll_pd, post_div, pre_half;
  logic [1:0] fmode;
  logic [3:0] n_int;
  logic [21:0] k_frac;
  logic [8:0] img_k_low, img_k_mid, img_n_k, img_mode;

  int checks = 0, errors = 0;
  logic [8:0] cur_img [4];
  logic cur_pd;
  int cur_fm, cur_po, cur_pr, cur_n;
  longint cur_k;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_frac_calc dut (
    .clk(clk), .rst(rst), .start(start), .ref_hz(ref_hz), .tgt_hz(tgt_hz),
    .cfg_keep(cfg_keep), .busy(busy), .done(done), .err(err), .pll_pd(pll_pd),
    .fmode(fmode), .post_div(post_div), .pre_half(pre_half), .n_int(n_int),
    .k_frac(k_frac), .img_k_low(img_k_low), .img_k_mid(img_k_mid),
    .img_n_k(img_n_k), .img_mode(img_mode));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model built from R1..R5; ecode 0 ok, 2 window miss, 4 N range
  task automatic model(input longint r, input longint t, output int ecode,
                       output int fm, output int po, output int pr,
                       output int n, output longint k);
    int dv [8] = '{2, 4, 4, 8, 8, 16, 12, 24};
    int fmt[8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    int pst[8] = '{0, 1, 0, 1, 0, 1, 0, 1};
    longint sc = 0, rr, q;
    bit found = 0;
    ecode = 0; fm = 0; po = 0; pr = 0; n = 0; k = 0;
    for (int i = 0; i < 8; i++)
      if (!found && t * dv[i] >= 90_000_000 && t * dv[i] <= 100_000_000) begin
        found = 1; fm = fmt[i]; po = pst[i]; sc = t * dv[i];
      end
    if (!found) begin ecode = 2; return; end
    rr = r; q = sc / rr;
    if (q < 5) begin rr = r / 2; pr = 1; q = sc / rr; end
    if (q < 5 || q > 13) begin ecode = 4; return; end
    n = int'(q);
    k = ((sc % rr) << 22) / rr;
  endtask

  task automatic launch(input logic [31:0] r, input logic [31:0] t, input logic [8:0] kp);
    @(negedge clk);
    ref_hz = r; tgt_hz = t; cfg_keep = kp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done while watching that words only move under power-down
  task automatic wait_done(output int lat);
    logic [35:0] prev;
    lat = 1;
    prev = {img_k_low, img_k_mid, img_n_k, img_mode};
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
      if ({img_k_low, img_k_mid, img_n_k, img_mode} != prev)
        chk("R8 words changed while released", pll_pd, 1);
      prev = {img_k_low, img_k_mid, img_n_k, img_mode};
    end
    chk("R12 latency bound", (lat <= LAT_MAX), 1);
  endtask

  task automatic check_outputs(input string why);
    chk({"R1 fmode ", why}, fmode, cur_fm);
    chk({"R1 post_div ", why}, post_div, cur_po);
    chk({"R3 pre_half ", why}, pre_half, cur_pr);
    chk({"R3 n_int ", why}, n_int, cur_n);
    chk({"R5 k_frac ", why}, k_frac, cur_k);
    chk({"R6 word1 ", why}, img_k_low, cur_img[0]);
    chk({"R6 word2 ", why}, img_k_mid, cur_img[1]);
    chk({"R6 word3 ", why}, img_n_k, cur_img[2]);
    chk({"R7 word4 ", why}, img_mode, cur_img[3]);
    chk({"R8 power-down ", why}, pll_pd, cur_pd);
  endtask

  task automatic run_vec(input logic [31:0] r, input logic [31:0] t, input logic [8:0] kp);
    int ec, fm, po, pr, n, lat;
    longint k;
    model(r, t, ec, fm, po, pr, n, k);
    launch(r, t, kp);
    wait_done(lat);
    chk("R9 done seen", done, 1);
    if (ec == 2) chk("R2 window miss err", err, 1);
    else if (ec == 4) chk("R4 N range err", err, 1);
    else begin
      chk("R9 no err on valid", err, 0);
      cur_fm = fm; cur_po = po; cur_pr = pr; cur_n = n; cur_k = k; cur_pd = 1'b0;
      cur_img[0] = 9'(k & 'h1ff);
      cur_img[1] = 9'((k >> 9) & 'hff);
      cur_img[2] = 9'(((k >> 18) & 'hf) | (n << 4));
      cur_img[3] = {kp[8:6], 2'(fm), kp[3:2], 1'(po), 1'(pr)};
    end
    check_outputs(ec != 0 ? "(R9 hold on error)" : "");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0); chk("R11 err", err, 0); chk("R11 busy", busy, 0);
    chk("R11 pll_pd", pll_pd, 1);
    chk("R11 words", {img_k_low, img_k_mid, img_n_k, img_mode}, 0);
    chk("R11 n_int", n_int, 0); chk("R11 k_frac", k_frac, 0);
    cur_fm = 0; cur_po = 0; cur_pr = 0; cur_n = 0; cur_k = 0; cur_pd = 1'b1;
    for (int i = 0; i < 4; i++) cur_img[i] = '0;

    // table walk: edges, first-match order, prescale retry, error paths
    for (int i = 0; i < NV; i++)
      run_vec(V_REF[i], V_TGT[i], 9'(9'h1C5 + i * 37));

    // R10: second start during a run is ignored
    begin
      int ec, fm, po, pr, n;
      longint k;
      model(64'(V_REF[0]), 64'(V_TGT[0]), ec, fm, po, pr, n, k);
      launch(V_REF[0], V_TGT[0], 9'h000);
      repeat (5) @(negedge clk);
      chk("R10 busy mid-run", busy, 1);
      ref_hz = V_REF[9]; tgt_hz = V_TGT[9]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      chk("R10 no err from ignored start", err, 0);
      chk("R10 n_int from first operands", n_int, n);
      chk("R10 k_frac from first operands", k_frac, k);
      cur_fm = fm; cur_po = po; cur_pr = pr; cur_n = n; cur_k = k; cur_pd = 1'b0;
      cur_img[0] = 9'(k & 'h1ff);
      cur_img[1] = 9'((k >> 9) & 'hff);
      cur_img[2] = 9'(((k >> 18) & 'hf) | (n << 4));
      cur_img[3] = {3'b0, 2'(fm), 2'b0, 1'(po), 1'(pr)};
      @(negedge clk);
      chk("R10 no second done", done, 0);
      chk("R10 idle after", busy, 0);
    end

    // R8: zero reference, then zero target: power down, nothing else moves
    launch(32'd0, 32'd12_288_000, 9'h1FF);
    wait_done(lat);
    chk("R8 zero ref no err", err, 0);
    cur_pd = 1'b1;
    check_outputs("(R8 zero ref)");
    run_vec(V_REF[0], V_TGT[0], 9'h0AA);
    launch(32'd12_000_000, 32'd0, 9'h155);
    wait_done(lat);
    chk("R8 zero tgt no err", err, 0);
    cur_pd = 1'b1;
    check_outputs("(R8 zero tgt)");

    // R9: error after a powered-down state keeps power-down high
    run_vec(V_REF[10], V_TGT[10], 9'h033);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule